// File: doc/BRIEF.md
# Two-Stage Reload Interval Timer

This block is an interval timer made of two down-counting stages in series. A prescaler stage counts strobes from one of four selectable count sources, and each time it wraps it advances a main counter stage by one. Each stage holds its own reload value and restarts from it after passing zero. When the main counter wraps, the block raises a sticky interrupt request. The interrupt period is therefore the product of the two stage lengths.

Software reaches the block over a small register bus. It can start and stop counting, choose the count source and clear the interrupt flag. It can also read the live count of either stage. A control bit decides whether a write to a stage sets both the reload value and the running count, or the reload value alone. The count sources reach the block as single-cycle strobes. Three of them are clock-rate enables, and the fourth is the wrap pulse of an upstream timer.

Top module: `cascade_timer`

## Requirements
- R1: The source field (control bits 3:2) picks which strobe advances the prescaler: 00 picks tick_div1, 01 tick_div2, 10 tick_div8, 11 tick_upstream. Strobes on the unselected inputs have no effect.
- R2: The prescaler steps down once for each strobe of the selected source. The main counter steps down only in a cycle where the prescaler wraps from 0. Each stage, on stepping from 0, reloads from its own reload register.
- R3: With prescaler reload n and main reload m, loaded into both registers while stopped, the interrupt flag first rises after exactly (n+1)*(m+1) selected strobes.
- R4: Control bit 0 is the run bit. While it is 0, both counts hold their values. Writing 1 starts counting, and writing 0 stops it.
- R5: The interrupt flag (control bit 7, also driven on irq) is set in the cycle after the main counter wraps.
- R6: The flag stays set until a control write with bit 7 equal to 0 clears it. Writing 1 to bit 7 has no effect. If a set condition occurs in the same cycle as a clear, the flag stays set.
- R7: bus_rdata shows, one cycle after bus_addr is presented, the register at that address as it stood before the clock edge. Address 1 gives the live prescaler count and address 2 the live main count, not their reload values. Address 0 gives the control register, with unused bits reading 0. Address 3 reads as 0.
- R8: Control bit 1 is the reload-only bit. When it is 0, a write to address 1 or 2 loads both the reload register and the count. When it is 1, such a write loads only the reload register, and the count keeps its value until that stage next wraps.
- R9: A write to address 1 or 2 while the reload-only bit is 0 and the run bit is 1 sets the interrupt flag.
- R10: Synchronous reset clears the control register and the flag. It sets both counts and both reload registers to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_div1 | input | 1 | Count strobe at the full clock-enable rate |
| tick_div2 | input | 1 | Count strobe at one half of the rate |
| tick_div8 | input | 1 | Count strobe at one eighth of the rate |
| tick_upstream | input | 1 | Wrap pulse of an upstream timer |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 prescaler, 2 main counter |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request flag |

## Verification
Some properties are checked on every cycle. These are that both counts hold while the run bit is clear, except when a write loads them. The main count changes only on a prescaler wrap or a write. The flag never rises without a main-counter wrap or a write-through while running, and it never falls except through a clearing control write. Reset leaves the 0xFF values in place. Other properties only the bench scenarios can show. These are the exact (n+1)*(m+1) period, the rejection of unselected strobes, the delayed effect of reload-only writes, and the read-back values. A model checks them under directed cases and seeded random traffic.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;
  typedef enum logic [1:0] {
    SRC_DIV1     = 2'b00,
    SRC_DIV2     = 2'b01,
    SRC_DIV8     = 2'b10,
    SRC_UPSTREAM = 2'b11
  } src_t;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_RO_BIT   = 1;
  localparam int CTRL_SRC_LSB  = 2;
  localparam int CTRL_FLAG_BIT = 7;

  localparam int ADDR_CTRL = 0;
  localparam int ADDR_PRE  = 1;
  localparam int ADDR_MAIN = 2;
endpackage

// File: rtl/cascade_src_mux.sv
module cascade_src_mux
  import cascade_timer_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic [NSRC-1:0]         strobes,
  input  logic [$clog2(NSRC)-1:0] sel,
  input  logic                    enable,
  output logic                    step
);
  logic [NSRC-1:0] hit;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = strobes[i] && (sel == i[$clog2(NSRC)-1:0]);
  end

  assign step = enable && (|hit);
endmodule

// File: rtl/cascade_stage.sv
module cascade_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dec,
  input  logic         ld_rld,
  input  logic         ld_cnt,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] rld,
  output logic         wrap
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  assign wrap = dec && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= ALL_ONES;
      rld <= ALL_ONES;
    end else begin
      if (ld_rld) rld <= wdata;
      if (ld_cnt) cnt <= wdata;
      else if (dec) cnt <= (cnt == '0) ? rld : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
  import cascade_timer_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2,
  parameter int PW = 8,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_div1,
  input  logic          tick_div2,
  input  logic          tick_div8,
  input  logic          tick_upstream,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int NSRC = 4;
  localparam int SW   = $clog2(NSRC);

  logic          run_q, ro_q, irq_q;
  src_t          src_q;
  logic          wr_ctrl, wr_pre, wr_main;
  logic          pre_step, pre_wrap, main_wrap;
  logic [PW-1:0] pre_cnt, pre_rld;
  logic [MW-1:0] main_cnt, main_rld;
  logic          flag_set, flag_clr;
  logic [DW-1:0] ctrl_view, rd_next;

  assign wr_ctrl = bus_we && (bus_addr == AW'(ADDR_CTRL));
  assign wr_pre  = bus_we && (bus_addr == AW'(ADDR_PRE));
  assign wr_main = bus_we && (bus_addr == AW'(ADDR_MAIN));

  cascade_src_mux #(.NSRC(NSRC)) u_mux (
    .strobes ({tick_upstream, tick_div8, tick_div2, tick_div1}),
    .sel     (SW'(src_q)),
    .enable  (run_q),
    .step    (pre_step)
  );

  cascade_stage #(.W(PW)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .dec    (pre_step),
    .ld_rld (wr_pre),
    .ld_cnt (wr_pre && !ro_q),
    .wdata  (bus_wdata[PW-1:0]),
    .cnt    (pre_cnt),
    .rld    (pre_rld),
    .wrap   (pre_wrap)
  );

  cascade_stage #(.W(MW)) u_main (
    .clk    (clk),
    .rst    (rst),
    .dec    (pre_wrap),
    .ld_rld (wr_main),
    .ld_cnt (wr_main && !ro_q),
    .wdata  (bus_wdata[MW-1:0]),
    .cnt    (main_cnt),
    .rld    (main_rld),
    .wrap   (main_wrap)
  );

  assign flag_set = main_wrap || ((wr_pre || wr_main) && !ro_q && run_q);
  assign flag_clr = wr_ctrl && !bus_wdata[CTRL_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      ro_q  <= 1'b0;
      src_q <= SRC_DIV1;
      irq_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run_q <= bus_wdata[CTRL_RUN_BIT];
        ro_q  <= bus_wdata[CTRL_RO_BIT];
        src_q <= src_t'(bus_wdata[CTRL_SRC_LSB +: SW]);
      end
      if (flag_set)      irq_q <= 1'b1;
      else if (flag_clr) irq_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_view                       = '0;
    ctrl_view[CTRL_RUN_BIT]         = run_q;
    ctrl_view[CTRL_RO_BIT]          = ro_q;
    ctrl_view[CTRL_SRC_LSB +: SW]   = SW'(src_q);
    ctrl_view[CTRL_FLAG_BIT]        = irq_q;
    case (bus_addr)
      AW'(ADDR_CTRL): rd_next = ctrl_view;
      AW'(ADDR_PRE):  rd_next = DW'(pre_cnt);
      AW'(ADDR_MAIN): rd_next = DW'(main_cnt);
      default:        rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  assign irq = irq_q;
endmodule

// File: rtl/cascade_timer_chk.sv
module cascade_timer_chk #(
  parameter int DW = 8,
  parameter int AW = 2,
  parameter int PW = 8,
  parameter int MW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          ro,
  input logic          pre_wrap,
  input logic          main_wrap,
  input logic [PW-1:0] pre_cnt,
  input logic [PW-1:0] pre_rld,
  input logic [MW-1:0] main_cnt,
  input logic [MW-1:0] main_rld,
  input logic          irq,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata
);
  logic stage_wr, side_set, clr_wr;
  assign stage_wr = bus_we && (bus_addr == AW'(1) || bus_addr == AW'(2));
  assign side_set = stage_wr && !ro && run;
  assign clr_wr   = bus_we && (bus_addr == AW'(0)) && !bus_wdata[7];

  // R4: stopped counters hold unless a write loads them
  assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (rst)
    (!run && !bus_we) |=> ($stable(pre_cnt) && $stable(main_cnt)));

  // R2: main counter moves only on a prescaler wrap or a write
  assert_main_steps_on_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (!pre_wrap && !bus_we) |=> $stable(main_cnt));

  // R5, R9: flag rises only from a wrap or a write-through while running
  assert_flag_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(main_wrap || side_set));

  // R6: flag is sticky until a clearing control write
  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr_wr) |=> irq);

  // R10: reset leaves reload values and counts at all ones
  assert_reset_values_R10: assert property (@(posedge clk)
    rst |=> (pre_rld == {PW{1'b1}} && main_rld == {MW{1'b1}} &&
             pre_cnt == {PW{1'b1}} && main_cnt == {MW{1'b1}} && !irq));
endmodule

bind cascade_timer cascade_timer_chk #(.DW(DW), .AW(AW), .PW(PW), .MW(MW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .run       (run_q),
  .ro        (ro_q),
  .pre_wrap  (pre_wrap),
  .main_wrap (main_wrap),
  .pre_cnt   (pre_cnt),
  .pre_rld   (pre_rld),
  .main_cnt  (main_cnt),
  .main_rld  (main_rld),
  .irq       (irq_q),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata)
);

// File: tb/tb_cascade_timer.sv
module tb_cascade_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_div1 = 0, tick_div2 = 0, tick_div8 = 0, tick_upstream = 0;
  logic       bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model of the register state
  bit       m_run, m_ro, m_flag;
  bit [1:0] m_src;
  bit [7:0] m_pre, m_prl, m_main, m_mrl;
  bit [7:0] exp_rd;

  always #5 clk = ~clk;

  cascade_timer dut (
    .clk(clk), .rst(rst), .tick_div1(tick_div1), .tick_div2(tick_div2),
    .tick_div8(tick_div8), .tick_upstream(tick_upstream), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic bit [7:0] mread(input bit [1:0] a);
    case (a)
      2'd0: return {m_flag, 3'b000, m_src, m_ro, m_run};
      2'd1: return m_pre;
      2'd2: return m_main;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    m_run = 0; m_ro = 0; m_flag = 0; m_src = 0;
    m_pre = 8'hFF; m_prl = 8'hFF; m_main = 8'hFF; m_mrl = 8'hFF;
  endtask

  task automatic model_step(input bit we, input bit [1:0] a, input bit [7:0] d, input bit [3:0] stb);
    bit tick, pw, mw, setf;
    bit [7:0] np, nm;
    tick = m_run && stb[m_src];
    pw = tick && (m_pre == 0);
    mw = pw && (m_main == 0);
    np = tick ? ((m_pre == 0) ? m_prl : m_pre - 8'd1) : m_pre;
    nm = pw ? ((m_main == 0) ? m_mrl : m_main - 8'd1) : m_main;
    setf = mw || (we && (a == 1 || a == 2) && !m_ro && m_run);
    if (we && a == 1) begin m_prl = d; if (!m_ro) np = d; end
    if (we && a == 2) begin m_mrl = d; if (!m_ro) nm = d; end
    if (setf) m_flag = 1;
    else if (we && a == 0 && !d[7]) m_flag = 0;
    if (we && a == 0) begin m_run = d[0]; m_ro = d[1]; m_src = d[3:2]; end
    m_pre = np; m_main = nm;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample after the edge
  task automatic step(input bit we, input bit [1:0] a, input bit [7:0] d, input bit [3:0] stb);
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d;
    {tick_upstream, tick_div8, tick_div2, tick_div1} = stb;
    exp_rd = mread(a);
    model_step(we, a, d, stb);
    @(posedge clk); #1;
    check("R7 model rdata", bus_rdata, exp_rd);
    check("R5 model irq", {7'b0, irq}, {7'b0, m_flag});
  endtask

  task automatic rd(input bit [1:0] a, output logic [7:0] v);
    step(0, a, 8'h00, 4'b0000);
    v = bus_rdata;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R10: reset values
    rd(2'd0, v); check("R10 ctrl after reset", v, 8'h00);
    rd(2'd1, v); check("R10 prescaler after reset", v, 8'hFF);
    rd(2'd2, v); check("R10 main after reset", v, 8'hFF);
    check("R10 irq after reset", {7'b0, irq}, 8'h00);
    rd(2'd3, v); check("R7 unused address", v, 8'h00);

    // R3: n=2, m=3 gives 12 strobes
    step(1, 2'd1, 8'd2, 4'b0);
    step(1, 2'd2, 8'd3, 4'b0);
    step(1, 2'd0, 8'h01, 4'b0);
    for (int k = 1; k <= 12; k++) begin
      step(0, 2'd2, 8'h00, 4'b0001);
      check("R3 period", {7'b0, irq}, {7'b0, k == 12});
    end
    // R2: both stages reloaded after the wrap
    rd(2'd1, v); check("R2 prescaler reload", v, 8'd2);
    rd(2'd2, v); check("R2 main reload", v, 8'd3);

    // R6: writing 1 keeps flag, writing 0 clears
    step(1, 2'd0, 8'h81, 4'b0);
    check("R6 write one keeps flag", {7'b0, irq}, 8'h01);
    step(1, 2'd0, 8'h05, 4'b0);
    check("R6 clear flag", {7'b0, irq}, 8'h00);

    // R1: source 01, div1 strobes ignored, div2 counted
    repeat (3) step(0, 2'd1, 8'h00, 4'b1101);
    rd(2'd1, v); check("R1 unselected strobes ignored", v, 8'd2);
    step(0, 2'd1, 8'h00, 4'b0010);
    rd(2'd1, v); check("R1 selected strobe counts", v, 8'd1);

    // R4: stop holds counts
    step(1, 2'd0, 8'h04, 4'b0);
    repeat (4) step(0, 2'd1, 8'h00, 4'b1111);
    rd(2'd1, v); check("R4 stopped hold", v, 8'd1);

    // R8: reload-only write keeps the live count
    step(1, 2'd0, 8'h06, 4'b0);
    step(1, 2'd1, 8'd5, 4'b0);
    rd(2'd1, v); check("R8 count unchanged", v, 8'd1);
    step(1, 2'd0, 8'h07, 4'b0);
    step(0, 2'd1, 8'h00, 4'b0010);
    step(0, 2'd1, 8'h00, 4'b0010);
    rd(2'd1, v); check("R8 new reload on wrap", v, 8'd5);

    // R9: write-through while running sets flag
    step(1, 2'd0, 8'h05, 4'b0);
    check("R9 flag clear before", {7'b0, irq}, 8'h00);
    step(1, 2'd2, 8'd9, 4'b0);
    check("R9 write-through sets flag", {7'b0, irq}, 8'h01);
    rd(2'd2, v); check("R8 both loaded", v, 8'd9);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      bit we; bit [1:0] a; bit [7:0] d;
      we = ($urandom % 12) == 0;
      a  = 2'($urandom);
      d  = 8'($urandom);
      if (we && a == 0) d[0] = ($urandom % 4) != 0;
      if (we && a != 0) d = d & 8'h07;
      step(we, a, d, 4'($urandom));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule